// File: doc/BRIEF.md
# Redundant-Lane Routing Configuration Controller

This block keeps the configuration of a twelve-output optical transmitter fed by eight serial receiver lanes. The first eight outputs follow receivers 0 to 7 directly. The four remaining outputs are spares. Each spare can be pointed at any of the eight receivers, so traffic can move off a primary emitter that has failed. Along with the routing, the block holds one 8-bit amplitude code for each output and one 8-bit bias code that all outputs share. It drives these codes straight to the analog converters.

Every configuration register is kept as three copies. The value seen at the outputs is the bitwise majority of the three. On every clock the voted value is written back into all three copies, so a single upset copy is repaired on the next edge. A sticky flag records that a repair took place.

The power-on reset loads defaults that leave the link usable even if no configuration ever arrives: a fixed amplitude code on every output, a fixed bias code, and every spare switched off. Software reaches the registers through a simple port with one address, one write strobe and a combinational read.

Top module: `lane_steer_cfg`

## Requirements
- R1: After reset, every amplitude code reads 8'h90, the bias code reads 8'h10, every spare routing field reads 0, and the upset flag is 0.
- R2: A write at address k in 0..11 stores cfg_wdata as the amplitude code of output k. From the clock edge of the write, that value appears on mod_code[8k+7:8k] and on cfg_rdata when cfg_addr is k.
- R3: A write at address 12 stores the shared bias code. It appears on bias_code and reads back at address 12.
- R4: For i in 0..7, tx_lane[i] always equals rx_lane[i].
- R5: Address 13+j (j in 0..3) holds the routing field of spare output j and stores only cfg_wdata[3:0]. Bit 3 is the enable and bits 2:0 are the receiver number. A read returns the field in bits 3:0 and zeros in bits 7:4. While the enable is 1, tx_lane[8+j] equals rx_lane[field[2:0]].
- R6: While the enable bit of spare j is 0, tx_lane[8+j] is 0 whatever the receiver inputs are.
- R7: Writes to addresses 17..31 change no register. Reads from those addresses return 0.
- R8: If one of the three copies of any register is corrupted, the voted outputs do not change. The bad copy is rewritten at the next clock edge, so a different copy can be corrupted in the following cycle, again with no visible effect.
- R9: upset_seen rises at the first clock edge at which any copy disagrees with its vote. It then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cfg_we | input | 1 | Write strobe for the register at cfg_addr |
| cfg_addr | input | 5 | Register address for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Voted content of the register at cfg_addr, 0 if unmapped |
| rx_lane | input | 8 | Receiver lane bits |
| tx_lane | output | 12 | Driver lane bits: 8 primaries, then 4 spares |
| mod_code | output | 96 | Amplitude codes, output k in bits 8k+7:8k |
| bias_code | output | 8 | Shared bias code |
| upset_seen | output | 1 | Sticky flag: a copy was repaired since reset |

## Verification
The assertions assume two things. First, a corruption hits at most one copy of a register in any cycle. Second, nothing corrupts a copy in the cycle that follows a write to that register or the first cycle after reset. The write and reset checks rely on that. The stimulus corrupts copies only on falling edges, one copy per cycle, on registers that are idle. It keeps write strobes clear of those cycles and writes only through the port, so the vote that the properties compare against is always well defined.

// File: rtl/lane_steer_pkg.sv
// Package lane_steer_pkg
// Shared helpers for the lane steering configuration block.
// Assumes: all operands to the majority function share one width.
package lane_steer_pkg;

    // Bitwise two-of-three vote over an 8-bit-wide container.
    function automatic logic [7:0] vote3(input logic [7:0] a,
                                         input logic [7:0] b,
                                         input logic [7:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tmr_reg.sv
// Module tmr_reg
// One configuration register kept as three copies. The output is the bitwise
// majority of the copies. Each clock writes either new data or the current
// vote back into all copies, so one bad copy lasts at most one cycle.
// Assumes: W is at most 8; at most one copy is disturbed in any cycle.
module tmr_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         mismatch
);
    import lane_steer_pkg::*;

    logic [W-1:0] copy_q [3];
    logic [7:0]   voted8;

    // Majority vote of the three copies, evaluated in a byte container.
    assign voted8   = vote3(8'(copy_q[0]), 8'(copy_q[1]), 8'(copy_q[2]));
    assign q        = voted8[W-1:0];
    // Any copy that disagrees with the vote marks a repair this cycle.
    assign mismatch = (copy_q[0] != q) || (copy_q[1] != q) || (copy_q[2] != q);

    // Load reset default, new data, or the scrubbed vote into every copy.
    always_ff @(posedge clk) begin
        for (int c = 0; c < 3; c++) begin
            if (!rst_n)
                copy_q[c] <= RESET_VAL;
            else if (we)
                copy_q[c] <= d;
            else
                copy_q[c] <= q;
        end
    end

    // R1: the first cycle out of reset shows the default.
    a_r1_reset_default : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == RESET_VAL));

    // R2: written data is what the vote shows one edge later.
    a_r2_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

endmodule

// File: rtl/cfg_regfile.sv
// Module cfg_regfile
// Register map for amplitude codes, shared bias and spare routing fields,
// each built from a tmr_reg. Provides a combinational read port and the
// OR of every register's repair indication.
// Assumes: address space of 2**ADDR_W is at least the register count.
module cfg_regfile #(
    parameter int NUM_OUT   = 12,
    parameter int NUM_SPARE = 4,
    parameter int CODE_W    = 8,
    parameter int ROUTE_W   = 4,
    parameter int ADDR_W    = 5,
    parameter logic [CODE_W-1:0] MOD_DEFAULT  = 8'h90,
    parameter logic [CODE_W-1:0] BIAS_DEFAULT = 8'h10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CODE_W-1:0]             wdata,
    output logic [CODE_W-1:0]             rdata,
    output logic [NUM_OUT*CODE_W-1:0]     mod_codes,
    output logic [CODE_W-1:0]             bias,
    output logic [NUM_SPARE*ROUTE_W-1:0]  spare_fields,
    output logic                          any_mismatch
);
    localparam int BIAS_IDX = NUM_OUT;
    localparam int NREG     = NUM_OUT + 1 + NUM_SPARE;

    logic [CODE_W-1:0] voted [NREG];
    logic [NREG-1:0]   mis;

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam int RW = (k <= BIAS_IDX) ? CODE_W : ROUTE_W;
        localparam logic [RW-1:0] RV = (k < NUM_OUT)  ? RW'(MOD_DEFAULT)  :
                                       (k == BIAS_IDX) ? RW'(BIAS_DEFAULT) : '0;
        logic         sel_we;
        logic [RW-1:0] q_k;

        // Decode the write strobe for this slot.
        assign sel_we = we && (addr == ADDR_W'(k));

        tmr_reg #(.W(RW), .RESET_VAL(RV)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (sel_we),
            .d        (wdata[RW-1:0]),
            .q        (q_k),
            .mismatch (mis[k])
        );

        // Zero-extend the vote into the common read container.
        assign voted[k] = CODE_W'(q_k);
    end

    for (genvar m = 0; m < NUM_OUT; m++) begin : g_mod_out
        // Amplitude code fan-out per output.
        assign mod_codes[m*CODE_W +: CODE_W] = voted[m];
    end

    for (genvar s = 0; s < NUM_SPARE; s++) begin : g_spare_out
        // Routing field fan-out per spare.
        assign spare_fields[s*ROUTE_W +: ROUTE_W] = voted[BIAS_IDX+1+s][ROUTE_W-1:0];
    end

    assign bias         = voted[BIAS_IDX];
    assign any_mismatch = |mis;

    // Read mux: mapped slot returns its vote, anything else returns zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++)
            if (addr == ADDR_W'(k))
                rdata = voted[k];
    end

    // R7: a write outside the map leaves every stored code untouched.
    a_r7_unmapped_write : assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr >= ADDR_W'(NREG))) |=>
            ($stable(mod_codes) && $stable(bias) && $stable(spare_fields)));

endmodule

// File: rtl/spare_router.sv
// Module spare_router
// Lane crossbar: primaries pass straight through, each spare picks one
// receiver through its routing field or sits idle at 0.
// Assumes: field layout is {enable, receiver select}; NUM_RX is a power of 2.
module spare_router #(
    parameter int NUM_RX    = 8,
    parameter int NUM_SPARE = 4,
    parameter int ROUTE_W   = 4
) (
    input  logic [NUM_RX-1:0]            rx,
    input  logic [NUM_SPARE*ROUTE_W-1:0] fields,
    output logic [NUM_RX+NUM_SPARE-1:0]  tx
);
    localparam int SEL_W = ROUTE_W - 1;

    // Primary outputs are hard-wired to their receivers.
    assign tx[NUM_RX-1:0] = rx;

    for (genvar s = 0; s < NUM_SPARE; s++) begin : g_spare
        logic [SEL_W-1:0] sel;
        logic             en;
        assign sel = fields[s*ROUTE_W +: SEL_W];
        assign en  = fields[s*ROUTE_W + SEL_W];
        // Spare mux, gated idle when not enabled.
        assign tx[NUM_RX+s] = en & rx[sel];
    end

endmodule

// File: rtl/lane_steer_cfg.sv
// Module lane_steer_cfg
// Top of the redundant-lane configuration controller: triplicated register
// map, spare lane steering, and a sticky repaired-upset flag.
// Assumes: synchronous active-low reset held for at least one clock at power-up.
module lane_steer_cfg #(
    parameter int NUM_RX    = 8,
    parameter int NUM_OUT   = 12,
    parameter int CODE_W    = 8,
    parameter int ADDR_W    = 5,
    parameter logic [CODE_W-1:0] MOD_DEFAULT  = 8'h90,
    parameter logic [CODE_W-1:0] BIAS_DEFAULT = 8'h10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [CODE_W-1:0]         cfg_wdata,
    output logic [CODE_W-1:0]         cfg_rdata,
    input  logic [NUM_RX-1:0]         rx_lane,
    output logic [NUM_OUT-1:0]        tx_lane,
    output logic [NUM_OUT*CODE_W-1:0] mod_code,
    output logic [CODE_W-1:0]         bias_code,
    output logic                      upset_seen
);
    localparam int NUM_SPARE = NUM_OUT - NUM_RX;
    localparam int ROUTE_W   = $clog2(NUM_RX) + 1;

    logic [NUM_SPARE*ROUTE_W-1:0] spare_fields;
    logic                         any_mismatch;
    logic                         upset_q;

    cfg_regfile #(
        .NUM_OUT(NUM_OUT), .NUM_SPARE(NUM_SPARE), .CODE_W(CODE_W),
        .ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W),
        .MOD_DEFAULT(MOD_DEFAULT), .BIAS_DEFAULT(BIAS_DEFAULT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .addr         (cfg_addr),
        .wdata        (cfg_wdata),
        .rdata        (cfg_rdata),
        .mod_codes    (mod_code),
        .bias         (bias_code),
        .spare_fields (spare_fields),
        .any_mismatch (any_mismatch)
    );

    spare_router #(
        .NUM_RX(NUM_RX), .NUM_SPARE(NUM_SPARE), .ROUTE_W(ROUTE_W)
    ) u_router (
        .rx     (rx_lane),
        .fields (spare_fields),
        .tx     (tx_lane)
    );

    // Sticky capture of any repair since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upset_q <= 1'b0;
        else if (any_mismatch)
            upset_q <= 1'b1;
    end

    assign upset_seen = upset_q;

    // R9: once raised, the flag holds until reset.
    a_r9_flag_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        upset_seen |=> upset_seen);

    for (genvar s = 0; s < NUM_SPARE; s++) begin : g_chk
        // R6: a disabled spare never drives a 1.
        a_r6_spare_idle : assert property (@(posedge clk) disable iff (!rst_n)
            !spare_fields[s*ROUTE_W + ROUTE_W-1] |-> !tx_lane[NUM_RX+s]);
    end

endmodule

// File: tb/lane_steer_cfg_bench.sv
`timescale 1ns/100ps
module lane_steer_cfg_bench;
    localparam int NREG = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  rx_lane = '0;
    logic [11:0] tx_lane;
    logic [95:0] mod_code;
    logic [7:0]  bias_code;
    logic        upset_seen;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_reg [NREG];

    bit inj_go = 0;
    int inj_idx = 0;
    int inj_copy = 0;

    always #2.5 clk = ~clk;

    lane_steer_cfg u_lane_steer_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_lane(rx_lane),
        .tx_lane(tx_lane), .mod_code(mod_code), .bias_code(bias_code),
        .upset_seen(upset_seen)
    );

    // Fault injection: invert one copy of one register on a falling edge.
    for (genvar k = 0; k < NREG; k++) begin : g_inj
        always @(negedge clk) begin
            if (inj_go && inj_idx == k)
                u_lane_steer_cfg.u_regs.g_reg[k].u_reg.copy_q[inj_copy] =
                    ~u_lane_steer_cfg.u_regs.g_reg[k].u_reg.copy_q[inj_copy];
        end
    end

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = 5'(a);
        #1;
        check(req, 96'(cfg_rdata), 96'(exp));
    endtask

    task automatic inject(input int k, input int c);
        @(posedge clk);
        #1;
        inj_idx = k; inj_copy = c; inj_go = 1;
        @(negedge clk);
        #1;
        inj_go = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NREG; k++)
            exp_reg[k] = (k < 12) ? 8'h90 : (k == 12) ? 8'h10 : 8'h00;
    endtask

    task automatic check_all_regs(input string req);
        for (int k = 0; k < NREG; k++)
            rd_check(req, k, exp_reg[k]);
        #1;
        for (int k = 0; k < 12; k++)
            check(req, 96'(mod_code[k*8 +: 8]), 96'(exp_reg[k]));
        check(req, 96'(bias_code), 96'(exp_reg[12]));
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: defaults after reset, spares idle with all receivers high.
        check_all_regs("R1");
        rx_lane = 8'hff;
        #1;
        check("R1", 96'(tx_lane), 96'(12'h0ff));
        check("R1", 96'(upset_seen), 96'(1'b0));

        // R2: distinct amplitude codes per output.
        for (int k = 0; k < 12; k++) begin
            exp_reg[k] = 8'h21 + 8'(k) * 8'h0b;
            wr(k, exp_reg[k]);
        end
        // R3: shared bias code.
        exp_reg[12] = 8'h5a;
        wr(12, 8'h5a);
        check_all_regs("R2");
        check("R3", 96'(bias_code), 96'(8'h5a));

        // R4/R5: every spare against every receiver with one-hot and one-cold lanes.
        for (int j = 0; j < 4; j++) begin
            for (int s = 0; s < 8; s++) begin
                wr(13 + j, 8'hf8 | 8'(s));
                rd_check("R5", 13 + j, 8'h08 | 8'(s));
                for (int r = 0; r < 8; r++) begin
                    @(negedge clk);
                    rx_lane = 8'(1 << r);
                    #1;
                    check("R5", 96'(tx_lane[8+j]), 96'(r == s));
                    check("R4", 96'(tx_lane[7:0]), 96'(rx_lane));
                    @(negedge clk);
                    rx_lane = ~8'(1 << r);
                    #1;
                    check("R5", 96'(tx_lane[8+j]), 96'(r != s));
                    check("R4", 96'(tx_lane[7:0]), 96'(rx_lane));
                end
            end
            exp_reg[13+j] = 8'h08 | 8'(7 - j);
            wr(13 + j, exp_reg[13+j]);
        end

        // R6: enable cleared while a select is present.
        wr(14, 8'hf5);
        exp_reg[14] = 8'h05;
        rd_check("R6", 14, 8'h05);
        rx_lane = 8'hff;
        #1;
        check("R6", 96'(tx_lane[9]), 96'(1'b0));
        check("R6", 96'(tx_lane[8]), 96'(1'b1));

        // R7: unmapped writes are dropped and unmapped reads give zero.
        for (int a = 17; a < 32; a++) begin
            wr(a, 8'hff);
            rd_check("R7", a, 8'h00);
        end
        check_all_regs("R7");

        // R8/R9: corrupt each copy of each register in turn.
        check("R9", 96'(upset_seen), 96'(1'b0));
        for (int k = 0; k < NREG; k++) begin
            @(negedge clk);
            cfg_addr = 5'(k);
            for (int c = 0; c < 3; c++) begin
                inject(k, c);
                check("R8", 96'(cfg_rdata), 96'(exp_reg[k]));
                if (k == 0 && c == 0)
                    check("R9", 96'(upset_seen), 96'(1'b0));
            end
            @(negedge clk);
            #1;
            check("R9", 96'(upset_seen), 96'(1'b1));
        end
        check_all_regs("R8");

        // R1/R9: reset clears the flag and restores defaults.
        do_reset();
        #1;
        check("R9", 96'(upset_seen), 96'(1'b0));
        check_all_regs("R1");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule